// File: doc/BRIEF.md
# Bimodal Branch Predictor with Mispredict Redirect

This block predicts the direction of conditional branches for a five-stage in-order pipeline. It holds a table of 2-bit saturating counters. The table is selected by the word-address bits of the program counter. In the fetch stage it looks up the counter for the current fetch address. It returns a predicted-taken bit and the next fetch address, which is either the supplied branch target or the sequential address.

When a branch resolves in the execute stage, the pipeline presents the branch address, its real direction, its target and the direction that was predicted for it. The block moves the matching counter one step toward the real direction. If the prediction was wrong, the block raises flush strobes for the fetch/decode and decode/execute pipeline registers in that same cycle and supplies the corrected fetch address. A wrong prediction therefore costs exactly two squashed instructions. The branch target and the branch condition are computed outside this block.

Top module: `bpred_top`

## Requirements
- R1: After reset every counter holds weakly-not-taken (encoding 2'b01). Any fetch address then predicts not-taken, and a single taken resolution of that entry makes it predict taken.
- R2: `predTaken` is bit 1 of the counter selected by the fetch address. `predPc` equals `fetchTarget` when `predTaken` is 1, and `fetchPc + 4` otherwise.
- R3: The counter index is PC bits [7:2]. Addresses that differ only in bits [1:0], or only above bit 7, share one counter.
- R4: A taken resolution moves the counter up by one and saturates at strongly-taken (2'b11). After three or more taken resolutions, one not-taken resolution still leaves the entry predicting taken.
- R5: A not-taken resolution moves the counter down by one and saturates at strongly-not-taken (2'b00). After two or more not-taken resolutions from reset, one taken resolution still leaves the entry predicting not-taken.
- R6: A misprediction is `resValid` high with `resPredTaken` different from `resTaken`. In that same cycle, combinationally, both `flushIfId` and `flushIdEx` are 1. Otherwise both are 0.
- R7: `redirectValid` equals the misprediction condition of R6. While it is high, `redirectPc` is `resTarget` if `resTaken` is 1, and `resPc + 4` otherwise.
- R8: While `resValid` is low, no counter changes and no flush or redirect is raised, whatever the other resolve inputs carry.
- R9: A resolution updates its counter at the clock edge that ends the resolve cycle. A fetch of the same entry in that cycle sees the old value, and a fetch in the next cycle sees the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| fetchPc | input | 32 | Address being fetched |
| fetchTarget | input | 32 | Branch target for the fetched instruction |
| predTaken | output | 1 | Predicted direction for the fetched instruction |
| predPc | output | 32 | Predicted next fetch address |
| resValid | input | 1 | A branch resolves in execute this cycle |
| resPc | input | 32 | Address of the resolving branch |
| resTaken | input | 1 | Real direction of the resolving branch |
| resTarget | input | 32 | Real target of the resolving branch |
| resPredTaken | input | 1 | Direction that was predicted for the resolving branch |
| flushIfId | output | 1 | Squash the fetch/decode register |
| flushIdEx | output | 1 | Squash the decode/execute register |
| redirectValid | output | 1 | Fetch must restart at `redirectPc` |
| redirectPc | output | 32 | Corrected fetch address |

## Verification
A table of resolutions drives the same entry repeatedly: taken runs, not-taken runs, and alternations. These show the counter saturating at each end rather than wrapping, and they separate the weak states from the strong ones. Each resolution is given both a matching and a differing predicted bit, so that a flush and a redirect appear only on a disagreement, and the redirect address follows the real direction. Addresses that alias in index bits [7:2] but differ in bits [1:0] or above bit 7 show which bits select the entry. Idle cycles with a busy resolve bus show that nothing moves without `resValid`.

// File: rtl/bpred_pkg.sv
package bpred_pkg;

  typedef enum logic [1:0] {
    CNT_SNT = 2'b00,
    CNT_WNT = 2'b01,
    CNT_WT  = 2'b10,
    CNT_ST  = 2'b11
  } ctrState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic updateEn;
    logic mispredict;
    logic redirTaken;
  } bpStrobe_t;

  function automatic ctrState_t stepCounter(ctrState_t cur, logic taken);
    ctrState_t nxt;
    nxt = cur;
    if (taken) begin
      if (cur != CNT_ST) nxt = ctrState_t'(cur + 2'd1);
    end else begin
      if (cur != CNT_SNT) nxt = ctrState_t'(cur - 2'd1);
    end
    return nxt;
  endfunction

endpackage

// File: rtl/bpred_control.sv
module bpred_control
  import bpred_pkg::*;
(
  input  logic      resValid,
  input  logic      resTaken,
  input  logic      resPredTaken,
  output bpStrobe_t strobes,
  output logic      flushIfId,
  output logic      flushIdEx,
  output logic      redirectValid
);

  logic wrongGuess;

  always_comb begin
    wrongGuess         = resValid && (resPredTaken != resTaken);
    strobes.updateEn   = resValid;
    strobes.mispredict = wrongGuess;
    strobes.redirTaken = resTaken;
    // Two younger stages hold wrong-path instructions
    flushIfId          = wrongGuess;
    flushIdEx          = wrongGuess;
    redirectValid      = wrongGuess;
  end

endmodule

// File: rtl/bpred_datapath.sv
module bpred_datapath
  import bpred_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 64
) (
  input  logic            clk,
  input  logic            rstN,
  input  bpStrobe_t       strobes,
  input  logic [PC_W-1:0] fetchPc,
  input  logic [PC_W-1:0] fetchTarget,
  input  logic [PC_W-1:0] resPc,
  input  logic            resTaken,
  input  logic [PC_W-1:0] resTarget,
  output logic            predTaken,
  output logic [PC_W-1:0] predPc,
  output logic [PC_W-1:0] redirectPc
);

  localparam int IDX_W = $clog2(ENTRIES);
  localparam int IDX_LO = 2;
  localparam int IDX_HI = IDX_LO + IDX_W - 1;
  localparam logic [PC_W-1:0] INSTR_BYTES = PC_W'(4);

  ctrState_t ctrArr [ENTRIES];

  logic [IDX_W-1:0] fetchIdx;
  logic [IDX_W-1:0] updIdx;

  assign fetchIdx = fetchPc[IDX_HI:IDX_LO];
  assign updIdx   = resPc[IDX_HI:IDX_LO];

  for (genvar i = 0; i < ENTRIES; i++) begin : gEntry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ctrArr[i] <= CNT_WNT;
      end else if (strobes.updateEn && (updIdx == IDX_W'(i))) begin
        ctrArr[i] <= stepCounter(ctrArr[i], resTaken);
      end
    end
  end

  ctrState_t fetchCtr;

  always_comb begin
    fetchCtr  = ctrArr[fetchIdx];
    predTaken = fetchCtr[1];
    predPc    = predTaken ? fetchTarget : (fetchPc + INSTR_BYTES);
    if (strobes.mispredict && strobes.redirTaken) begin
      redirectPc = resTarget;
    end else begin
      redirectPc = resPc + INSTR_BYTES;
    end
  end

endmodule

// File: rtl/bpred_top.sv
module bpred_top
  import bpred_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 64
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] fetchPc,
  input  logic [PC_W-1:0] fetchTarget,
  output logic            predTaken,
  output logic [PC_W-1:0] predPc,
  input  logic            resValid,
  input  logic [PC_W-1:0] resPc,
  input  logic            resTaken,
  input  logic [PC_W-1:0] resTarget,
  input  logic            resPredTaken,
  output logic            flushIfId,
  output logic            flushIdEx,
  output logic            redirectValid,
  output logic [PC_W-1:0] redirectPc
);

  bpStrobe_t strobes;

  bpred_control u_ctrl (
    .resValid     (resValid),
    .resTaken     (resTaken),
    .resPredTaken (resPredTaken),
    .strobes      (strobes),
    .flushIfId    (flushIfId),
    .flushIdEx    (flushIdEx),
    .redirectValid(redirectValid)
  );

  bpred_datapath #(.PC_W(PC_W), .ENTRIES(ENTRIES)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .fetchPc    (fetchPc),
    .fetchTarget(fetchTarget),
    .resPc      (resPc),
    .resTaken   (resTaken),
    .resTarget  (resTarget),
    .predTaken  (predTaken),
    .predPc     (predPc),
    .redirectPc (redirectPc)
  );

endmodule

// File: rtl/bpred_checker.sv
module bpred_checker #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic [PC_W-1:0] fetchPc,
  input logic [PC_W-1:0] fetchTarget,
  input logic            predTaken,
  input logic [PC_W-1:0] predPc,
  input logic            resValid,
  input logic [PC_W-1:0] resPc,
  input logic            resTaken,
  input logic [PC_W-1:0] resTarget,
  input logic            resPredTaken,
  input logic            flushIfId,
  input logic            flushIdEx,
  input logic            redirectValid,
  input logic [PC_W-1:0] redirectPc
);

  assert_pred_target_R2: assert property (@(posedge clk) disable iff (!rstN)
    predTaken |-> (predPc == fetchTarget));

  assert_flush_on_miss_R6: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && (resTaken != resPredTaken)) |-> (flushIfId && flushIdEx));

  assert_redirect_dest_R7: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |-> (redirectPc == (resTaken ? resTarget : resPc + PC_W'(4))));

  assert_quiet_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    !resValid |-> (!flushIfId && !flushIdEx && !redirectValid));

  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    !resValid |=> ((fetchPc != $past(fetchPc)) || (predTaken == $past(predTaken))));

  assert_sat_taken_R4: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resTaken && (fetchPc == resPc) && predTaken)
      |=> ((fetchPc != $past(resPc)) || predTaken));

  assert_sat_nottaken_R5: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !resTaken && (fetchPc == resPc) && !predTaken)
      |=> ((fetchPc != $past(resPc)) || !predTaken));

endmodule

bind bpred_top bpred_checker #(.PC_W(PC_W)) u_chk (.*);

// File: tb/bpred_top_test.sv
module bpred_top_test;

  localparam int PERIOD = 10;
  localparam int NVEC = 12;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] fetchPc = '0;
  logic [31:0] fetchTarget = '0;
  logic        predTaken;
  logic [31:0] predPc;
  logic        resValid = 1'b0;
  logic [31:0] resPc = '0;
  logic        resTaken = 1'b0;
  logic [31:0] resTarget = '0;
  logic        resPredTaken = 1'b0;
  logic        flushIfId;
  logic        flushIdEx;
  logic        redirectValid;
  logic [31:0] redirectPc;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [1:0] model [64];

  // {pc, taken, predicted bit}
  localparam logic [33:0] VEC [NVEC] = '{
    {32'h0000_0100, 1'b1, 1'b0},
    {32'h0000_0100, 1'b1, 1'b1},
    {32'h0000_0100, 1'b1, 1'b1},
    {32'h0000_0100, 1'b0, 1'b1},
    {32'h0000_0200, 1'b0, 1'b1},
    {32'h0000_0204, 1'b0, 1'b0},
    {32'h0000_0204, 1'b0, 1'b0},
    {32'h0000_0204, 1'b1, 1'b0},
    {32'h0000_0206, 1'b1, 1'b0},
    {32'h0000_1204, 1'b0, 1'b1},
    {32'h0000_03FC, 1'b0, 1'b0},
    {32'h0000_03FC, 1'b1, 1'b1}
  };

  bpred_top uut (.*);

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [5:0] idxOf(logic [31:0] pc);
    return pc[7:2];
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic checkPredict(string req, logic [31:0] pc);
    logic expT;
    expT = model[idxOf(pc)][1];
    check(req, "predTaken", {31'b0, predTaken}, {31'b0, expT});
    check("R2", "predPc", predPc, expT ? fetchTarget : pc + 32'd4);
  endtask

  // One resolve cycle; outputs compared mid-cycle, model updated at the edge
  task automatic resolveStep(logic [31:0] pc, logic tk, logic pb);
    logic miss;
    @(negedge clk);
    fetchPc      = pc;
    fetchTarget  = pc ^ 32'h0000_8000;
    resValid     = 1'b1;
    resPc        = pc;
    resTaken     = tk;
    resTarget    = pc + 32'h40;
    resPredTaken = pb;
    #1;
    miss = (tk != pb);
    checkPredict("R9", pc);
    check("R6", "flushIfId", {31'b0, flushIfId}, {31'b0, miss});
    check("R6", "flushIdEx", {31'b0, flushIdEx}, {31'b0, miss});
    check("R7", "redirectValid", {31'b0, redirectValid}, {31'b0, miss});
    if (miss) check("R7", "redirectPc", redirectPc, tk ? pc + 32'h40 : pc + 32'd4);
    @(posedge clk);
    if (tk && model[idxOf(pc)] != 2'b11) model[idxOf(pc)] = model[idxOf(pc)] + 2'd1;
    if (!tk && model[idxOf(pc)] != 2'b00) model[idxOf(pc)] = model[idxOf(pc)] - 2'd1;
  endtask

  task automatic fetchOnly(string req, logic [31:0] pc);
    @(negedge clk);
    resValid    = 1'b0;
    fetchPc     = pc;
    fetchTarget = pc ^ 32'h0000_8000;
    #1;
    checkPredict(req, pc);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) model[i] = 2'b01;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: reset state across several entries
    fetchOnly("R1", 32'h0000_0000);
    fetchOnly("R1", 32'h0000_0100);
    fetchOnly("R1", 32'h0000_03FC);
    check("R1", "flush after reset", {31'b0, flushIfId}, 32'd0);

    // Vector table: R3 R4 R5 R6 R7 R9
    for (int v = 0; v < NVEC; v++) begin
      resolveStep(VEC[v][33:2], VEC[v][1], VEC[v][0]);
      fetchOnly("R9", VEC[v][33:2]);
    end
    // R3: aliased address above bit 7 and low bits
    fetchOnly("R3", 32'h0000_0103);
    fetchOnly("R3", 32'h0001_0207);

    // R8: busy resolve bus without valid
    @(negedge clk);
    fetchPc      = 32'h0000_0108;
    fetchTarget  = 32'h0000_9108;
    resValid     = 1'b0;
    resPc        = 32'h0000_0108;
    resTaken     = 1'b1;
    resPredTaken = 1'b0;
    resTarget    = 32'h0000_0500;
    #1;
    check("R8", "flushIfId idle", {31'b0, flushIfId}, 32'd0);
    check("R8", "redirectValid idle", {31'b0, redirectValid}, 32'd0);
    repeat (3) @(posedge clk);
    fetchOnly("R8", 32'h0000_0108);

    // R1: single taken from reset flips a fresh entry
    resolveStep(32'h0000_0010, 1'b1, 1'b0);
    fetchOnly("R1", 32'h0000_0010);
    check("R1", "fresh entry taken", {31'b0, predTaken}, 32'd1);

    // R5: saturation at not-taken end
    resolveStep(32'h0000_0020, 1'b0, 1'b0);
    resolveStep(32'h0000_0020, 1'b0, 1'b0);
    resolveStep(32'h0000_0020, 1'b0, 1'b0);
    resolveStep(32'h0000_0020, 1'b1, 1'b0);
    fetchOnly("R5", 32'h0000_0020);
    check("R5", "still not taken", {31'b0, predTaken}, 32'd0);

    // R4: saturation at taken end
    for (int k = 0; k < 4; k++) resolveStep(32'h0000_0030, 1'b1, 1'b1);
    resolveStep(32'h0000_0030, 1'b0, 1'b1);
    fetchOnly("R4", 32'h0000_0030);
    check("R4", "still taken", {31'b0, predTaken}, 32'd1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule